// File: doc/BRIEF.md
# Clock Frequency Window Monitor

This block checks that a monitored clock runs at roughly the expected rate compared with a trusted reference clock. It counts the rising edges of the monitored clock during a fixed measurement window. The window lasts 2^WIN_LOG2 reference cycles, which is 1024 by default. The count for a window is therefore about 2^WIN_LOG2 × (monitored frequency / reference frequency).

The edge counter runs in the monitored clock domain. At the end of each window, a toggle handshake carries the count into the reference domain. There it is compared with a programmable upper bound and a programmable lower bound.

A count outside the band sets a sticky out-of-range flag. Software clears the flag by writing 1 to the status location. The flag drives an interrupt when interrupts are enabled. The block only reports the condition. Any change of clock source is left to software.

Software picks the bounds around the expected count. For example, a 32 MHz monitored clock against a 48 MHz reference gives about 682.6 counts per 1024-cycle window, so bounds of 677 and 687 bracket it.

Top module: `clk_freq_window_mon`

## Requirements
- R1: Each completed window shows, on `last_count`, the number of monitored rising edges in 2^WIN_LOG2 reference cycles (within one edge). The result appears together with a one-cycle `cnt_upd` pulse.
- R2: Writes use `wr_addr`. Address 0 is control: bit 0 enables detection and bit 1 enables the interrupt. Address 1 is the upper bound. Address 2 is the lower bound. Address 3 is status: a 1 in bit 0 clears the flag.
- R3: A counted window sets `oor_flag` when the count is strictly above the upper bound or strictly below the lower bound. A count equal to either bound is in range.
- R4: `oor_flag` stays set until a status write with bit 0 at 1. A status write with bit 0 at 0 has no effect. A set in the same cycle as a clear wins.
- R5: `irq` is high exactly when `oor_flag` is high and the interrupt enable is set.
- R6: The first window that completes after detection is switched on is not compared, so its count cannot set the flag.
- R7: While detection is off, no new windows start, `cnt_upd` stays low once any handshake in flight has finished, and the flag does not change except through a clear.
- R8: The edge counter saturates at 2^BOUND_W-1. A monitored clock far too fast therefore reads as the maximum count and not as a wrapped small value.
- R9: After reset, `oor_flag`, `irq`, `cnt_upd` and `last_count` are 0. Both enables are off, the upper bound is all ones and the lower bound is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; registers, window timer and compare |
| mon_clk | input | 1 | Monitored clock whose edges are counted |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Register write strobe (ref_clk domain) |
| wr_addr | input | 2 | Register select: 0 control, 1 upper, 2 lower, 3 status |
| wr_data | input | BOUND_W | Write data |
| last_count | output | BOUND_W | Count from the latest completed window |
| cnt_upd | output | 1 | One-cycle pulse when `last_count` takes a new value |
| oor_flag | output | 1 | Sticky out-of-range flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with WIN_LOG2 = 5 and BOUND_W = 6. A 32-cycle window keeps every phase of a run short. A 6-bit count reaches its ceiling of 63 with a monitored clock only a few times faster than the 200 MHz reference, so saturation is exercised.

With these sizes, monitored periods of 8 ns, 2 ns and 20 ns give exact counts of 20, saturated 63 and 8. The monitored and reference clocks keep a fixed phase relation, so the equal-to-bound case can be hit on purpose. A long disabled idle fills the counter up to saturation, which makes the discarded first window carry a value that would otherwise have set the flag.

// File: rtl/fwm_pkg.sv
package fwm_pkg;

   // Register select codes; the bench and software depend on these values.
   typedef enum logic [1:0] {
      FWM_CTRL  = 2'd0,
      FWM_UPPER = 2'd1,
      FWM_LOWER = 2'd2,
      FWM_STAT  = 2'd3
   } fwm_addr_e;

   localparam int CTRL_DET_BIT = 0;
   localparam int CTRL_IRQ_BIT = 1;
   localparam int STAT_CLR_BIT = 0;

endpackage

// File: rtl/fwm_sync.sv
module fwm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fwm_sync: STAGES must be at least 2");
      end
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[0], d};
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/fwm_mon_counter.sv
module fwm_mon_counter #(
   parameter int CNT_W       = 10,
   parameter int SYNC_STAGES = 2,
   parameter bit SATURATE    = 1'b1
) (
   input  logic             mon_clk,
   input  logic             rst_n,
   input  logic             req_tgl,
   output logic [CNT_W-1:0] hold_cnt,
   output logic             ack_tgl
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic             req_s, req_d, take;
   logic [CNT_W-1:0] cnt, cnt_inc;

   fwm_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(mon_clk), .rst_n(rst_n), .d(req_tgl), .q(req_s)
   );

   assign take = req_s ^ req_d;

   generate
      if (SATURATE) begin : g_sat
         assign cnt_inc = (cnt == CNT_MAX) ? CNT_MAX : cnt + CNT_ONE;
      end else begin : g_wrap
         assign cnt_inc = cnt + CNT_ONE;
      end
   endgenerate

   // The edge that sees the window boundary opens the next window.
   always_ff @(posedge mon_clk or negedge rst_n) begin
      if (!rst_n) begin
         req_d    <= 1'b0;
         cnt      <= '0;
         hold_cnt <= '0;
         ack_tgl  <= 1'b0;
      end else begin
         req_d <= req_s;
         if (take) begin
            hold_cnt <= cnt;
            cnt      <= CNT_ONE;
            ack_tgl  <= ~ack_tgl;
         end else begin
            cnt <= cnt_inc;
         end
      end
   end

   generate
      if (SATURATE) begin : g_sat_chk
         p_cnt_saturates_r8 : assert property (@(posedge mon_clk) disable iff (!rst_n)
            (cnt == CNT_MAX && !take) |=> (cnt == CNT_MAX));
      end
   endgenerate

   p_hold_stable_r1 : assert property (@(posedge mon_clk) disable iff (!rst_n)
      !take |=> $stable(hold_cnt));
endmodule

// File: rtl/fwm_window_timer.sv
module fwm_window_timer #(
   parameter int WIN_LOG2    = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic det_en,
   input  logic ack_tgl,
   output logic req_tgl,
   output logic cap_stb
);
   localparam logic [WIN_LOG2-1:0] WIN_LAST = {WIN_LOG2{1'b1}};

   logic [WIN_LOG2-1:0] win_cnt;
   logic                pending;
   logic                ack_s, ack_d;

   generate
      if (WIN_LOG2 < 4) begin : g_bad_win
         $error("fwm_window_timer: WIN_LOG2 must be at least 4");
      end
   endgenerate

   fwm_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(ref_clk), .rst_n(rst_n), .d(ack_tgl), .q(ack_s)
   );

   assign cap_stb = ack_s ^ ack_d;

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt <= '0;
         req_tgl <= 1'b0;
         pending <= 1'b0;
         ack_d   <= 1'b0;
      end else begin
         ack_d <= ack_s;
         if (!det_en) win_cnt <= '0;
         else         win_cnt <= win_cnt + 1'b1;
         if (det_en && win_cnt == WIN_LAST && !pending) begin
            req_tgl <= ~req_tgl;
            pending <= 1'b1;
         end else if (cap_stb) begin
            pending <= 1'b0;
         end
      end
   end

   p_ack_needs_req_r1 : assert property (@(posedge ref_clk) disable iff (!rst_n)
      cap_stb |-> pending);

   p_no_window_off_r7 : assert property (@(posedge ref_clk) disable iff (!rst_n)
      !$past(det_en) |-> $stable(req_tgl));
endmodule

// File: rtl/fwm_regs.sv
module fwm_regs #(
   parameter int BOUND_W = 10
) (
   input  logic               ref_clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_addr,
   input  logic [BOUND_W-1:0] wr_data,
   input  logic               cap_stb,
   input  logic [BOUND_W-1:0] hold_cnt,
   output logic               det_en,
   output logic [BOUND_W-1:0] last_count,
   output logic               cnt_upd,
   output logic               oor_flag,
   output logic               irq
);
   import fwm_pkg::*;

   logic               irq_en, skip;
   logic [BOUND_W-1:0] upper, lower;
   logic               wr_ctrl, wr_up, wr_lo, clr, outside, set;

   generate
      if (BOUND_W < 2) begin : g_bad_bound
         $error("fwm_regs: BOUND_W must be at least 2");
      end
   endgenerate

   assign wr_ctrl = wr_en && (wr_addr == FWM_CTRL);
   assign wr_up   = wr_en && (wr_addr == FWM_UPPER);
   assign wr_lo   = wr_en && (wr_addr == FWM_LOWER);
   assign clr     = wr_en && (wr_addr == FWM_STAT) && wr_data[STAT_CLR_BIT];
   assign outside = (hold_cnt > upper) || (hold_cnt < lower);
   assign set     = cap_stb && det_en && !skip && outside;

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         det_en     <= 1'b0;
         irq_en     <= 1'b0;
         skip       <= 1'b0;
         upper      <= '1;
         lower      <= '0;
         last_count <= '0;
         cnt_upd    <= 1'b0;
         oor_flag   <= 1'b0;
      end else begin
         cnt_upd <= cap_stb;
         if (cap_stb) last_count <= hold_cnt;
         if (wr_ctrl) begin
            det_en <= wr_data[CTRL_DET_BIT];
            irq_en <= wr_data[CTRL_IRQ_BIT];
         end
         if (wr_ctrl && wr_data[CTRL_DET_BIT] && !det_en) skip <= 1'b1;
         else if (cap_stb)                               skip <= 1'b0;
         if (wr_up) upper <= wr_data;
         if (wr_lo) lower <= wr_data;
         oor_flag <= set | (oor_flag & ~clr);
      end
   end

   assign irq = oor_flag & irq_en;

   p_set_on_outside_r3 : assert property (@(posedge ref_clk) disable iff (!rst_n)
      $rose(oor_flag) |-> $past(cap_stb && ((hold_cnt > upper) || (hold_cnt < lower))));

   p_flag_sticky_r4 : assert property (@(posedge ref_clk) disable iff (!rst_n)
      (oor_flag && !(wr_en && wr_addr == FWM_STAT && wr_data[STAT_CLR_BIT])) |=> oor_flag);

   p_first_window_dropped_r6 : assert property (@(posedge ref_clk) disable iff (!rst_n)
      $rose(oor_flag) |-> !$past(skip));

   p_no_flag_when_off_r7 : assert property (@(posedge ref_clk) disable iff (!rst_n)
      $rose(oor_flag) |-> $past(det_en));

   p_upd_pulse_r1 : assert property (@(posedge ref_clk) disable iff (!rst_n)
      cnt_upd |=> !cnt_upd);
endmodule

// File: rtl/clk_freq_window_mon.sv
module clk_freq_window_mon #(
   parameter int WIN_LOG2    = 10,
   parameter int BOUND_W     = 10,
   parameter int SYNC_STAGES = 2,
   parameter bit SATURATE    = 1'b1
) (
   input  logic               ref_clk,
   input  logic               mon_clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_addr,
   input  logic [BOUND_W-1:0] wr_data,
   output logic [BOUND_W-1:0] last_count,
   output logic               cnt_upd,
   output logic               oor_flag,
   output logic               irq
);
   logic               det_en, req_tgl, ack_tgl, cap_stb;
   logic [BOUND_W-1:0] hold_cnt;

   fwm_window_timer #(.WIN_LOG2(WIN_LOG2), .SYNC_STAGES(SYNC_STAGES)) u_timer (
      .ref_clk(ref_clk), .rst_n(rst_n), .det_en(det_en), .ack_tgl(ack_tgl),
      .req_tgl(req_tgl), .cap_stb(cap_stb)
   );

   fwm_mon_counter #(.CNT_W(BOUND_W), .SYNC_STAGES(SYNC_STAGES), .SATURATE(SATURATE)) u_count (
      .mon_clk(mon_clk), .rst_n(rst_n), .req_tgl(req_tgl),
      .hold_cnt(hold_cnt), .ack_tgl(ack_tgl)
   );

   fwm_regs #(.BOUND_W(BOUND_W)) u_regs (
      .ref_clk(ref_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cap_stb(cap_stb), .hold_cnt(hold_cnt),
      .det_en(det_en), .last_count(last_count), .cnt_upd(cnt_upd),
      .oor_flag(oor_flag), .irq(irq)
   );

   p_irq_needs_flag_r5 : assert property (@(posedge ref_clk) disable iff (!rst_n)
      irq |-> oor_flag);
endmodule

// File: tb/clk_freq_window_mon_test.sv
`timescale 1ns/1ps
module clk_freq_window_mon_test;
   localparam int WL   = 5;
   localparam int BW   = 6;
   localparam int CMAX = (1 << BW) - 1;

   logic          clk = 1'b0, mon_clk = 1'b0, rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = 2'd0;
   logic [BW-1:0] wr_data = '0;
   logic [BW-1:0] last_count;
   logic          cnt_upd, oor_flag, irq;
   real           mon_half = 4.0;
   int            n_tests = 0, n_fail = 0;

   // model state
   logic          s_we; logic [1:0] s_a; logic [BW-1:0] s_d;
   logic          m_det = 0, m_ien = 0, m_skip = 0, m_flag = 0;
   int            m_up = CMAX, m_lo = 0;
   int            seen_cnt = 0, upd_seen = 0;
   bit            run_model = 0, done = 0;

   clk_freq_window_mon #(.WIN_LOG2(WL), .BOUND_W(BW)) uut (
      .ref_clk(clk), .mon_clk(mon_clk), .rst_n(rst_n), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .last_count(last_count),
      .cnt_upd(cnt_upd), .oor_flag(oor_flag), .irq(irq)
   );

   always #2.5 clk = ~clk;
   always begin #(mon_half); mon_clk = ~mon_clk; end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin s_we <= wr_en; s_a <= wr_addr; s_d <= wr_data; end

   // Reference model, advanced and compared once per reference cycle.
   always @(negedge clk) begin
      if (run_model) begin
         bit set, clr;
         real expc;
         set = 0;
         if (cnt_upd) begin
            seen_cnt = last_count;
            upd_seen++;
            if (m_det && !m_skip) begin
               expc = (2.0 ** WL) * 5.0 / (2.0 * mon_half);
               if (expc >= CMAX)   // R8: saturation
                  check(last_count == CMAX, "R8", last_count, CMAX);
               else                // R1: window count
                  check((last_count >= int'(expc) - 1) && (last_count <= int'(expc) + 1),
                        "R1", last_count, int'(expc));
               set = (last_count > m_up) || (last_count < m_lo);
            end
            m_skip = 0;
         end
         clr = s_we && s_a == 2'd3 && s_d[0];
         if (s_we) begin   // R2: register map
            case (s_a)
               2'd0: begin
                  if (s_d[0] && !m_det) m_skip = 1;
                  m_det = s_d[0]; m_ien = s_d[1];
               end
               2'd1: m_up = s_d;
               2'd2: m_lo = s_d;
               default: ;
            endcase
         end
         m_flag = set | (m_flag & ~clr);   // R3 R4
         check(oor_flag == m_flag, "R3/R4 flag", oor_flag, m_flag);
         check(irq == (m_flag & m_ien), "R5", irq, m_flag & m_ien);
      end
   end

   task automatic wr(input logic [1:0] a, input int d);
      @(negedge clk); wr_en = 1; wr_addr = a; wr_data = BW'(d);
      @(negedge clk); wr_en = 0;
   endtask

   task automatic wait_upd();
      @(negedge clk);
      while (!cnt_upd) @(negedge clk);
   endtask

   task automatic wait_windows(input int n);
      for (int i = 0; i < n; i++) wait_upd();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R9: reset state
      check(oor_flag == 0, "R9 flag", oor_flag, 0);
      check(irq == 0, "R9 irq", irq, 0);
      check(cnt_upd == 0, "R9 upd", cnt_upd, 0);
      check(last_count == 0, "R9 count", last_count, 0);
      @(negedge clk); rst_n = 1; run_model = 1;
      repeat (3) @(negedge clk);
      check(oor_flag == 0 && cnt_upd == 0, "R9 after release", oor_flag, 0);

      // Nominal: 8 ns monitored period, count 20, band 10..30
      wr(2'd1, 30); wr(2'd2, 10); wr(2'd0, 3);
      wait_windows(6);
      check(oor_flag == 0, "R3 in band", oor_flag, 0);

      // R3: bounds equal to the count are in range
      wr(2'd1, seen_cnt); wr(2'd2, seen_cnt);
      wait_windows(4);
      check(oor_flag == 0, "R3 equal bound", oor_flag, 0);

      // R3: upper one below the count
      wr(2'd1, seen_cnt - 1);
      wait_windows(2);
      check(oor_flag == 1, "R3 above upper", oor_flag, 1);
      check(irq == 1, "R5 irq on", irq, 1);

      // R4: writing 0 to status changes nothing
      wr(2'd1, CMAX); wr(2'd2, 0); wr(2'd3, 0);
      repeat (3) @(negedge clk);
      check(oor_flag == 1, "R4 zero write", oor_flag, 1);
      wr(2'd3, 1);
      repeat (2) @(negedge clk);
      check(oor_flag == 0, "R4 clear", oor_flag, 0);

      // R5: interrupt masked, flag still sets below lower
      wr(2'd0, 1); wr(2'd2, seen_cnt + 1);
      wait_windows(2);
      check(oor_flag == 1, "R3 below lower", oor_flag, 1);
      check(irq == 0, "R5 masked", irq, 0);

      // R7: detection off, no windows, flag untouched
      wr(2'd0, 0); wr(2'd2, 10); wr(2'd1, 30);
      repeat (40) @(negedge clk);
      upd_seen = 0;
      repeat (400) @(negedge clk);
      check(upd_seen == 0, "R7 no updates", upd_seen, 0);
      check(oor_flag == 1, "R7 flag held", oor_flag, 1);
      wr(2'd3, 1);

      // R6: long idle saturates the counter; first window must not flag
      wr(2'd0, 3);
      wait_upd();
      check(oor_flag == 0, "R6 first window dropped", oor_flag, 0);
      wait_windows(3);
      check(oor_flag == 0, "R6 later windows", oor_flag, 0);

      // R8: fast monitored clock saturates
      wr(2'd0, 0); repeat (40) @(negedge clk);
      mon_half = 1.0;
      wr(2'd1, 40); wr(2'd0, 3);
      wait_windows(3);
      check(last_count == CMAX, "R8 saturated", last_count, CMAX);
      check(oor_flag == 1, "R8 flagged", oor_flag, 1);

      // Slow monitored clock: count 8, below lower 10
      wr(2'd0, 0); repeat (40) @(negedge clk);
      mon_half = 10.0;
      wr(2'd3, 1); wr(2'd1, 30); wr(2'd0, 3);
      wait_windows(3);
      check(last_count == 8, "R1 slow count", last_count, 8);
      check(oor_flag == 1, "R3 slow below", oor_flag, 1);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog R1 actual=timeout expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule